// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns the address and strobes of an 8051-style microcontroller bus into select lines for a set of on-chip memories. The memories are a bank of primary flash sectors, a bank of secondary flash sectors, and one SRAM / I/O region. Each memory region has an inclusive base/limit window, held in a small byte-wide register file. When windows overlap, three fixed tiers settle the conflict. The SRAM / I/O region always wins. Secondary flash comes next, and primary flash comes last.

An 8-bit mapping register decides, at run time, which memories answer program fetches and which answer data accesses. The map can therefore be changed on the fly. One example is moving from separate program and data spaces to a single combined space. The block also flags configuration mistakes. One kind is two windows of the same tier matching the current address. The other is a flash window that is wider than its physical sector.

Top module: `memsel_decode`

## Requirements
- R1: After reset the mapping register holds `MAP_BOOT` (default 0Ch). Every window is disabled (base FFFFh, limit 0000h), so no select is active.
- R2: When none of `fetch_i`, `rd_i`, `wr_i` is high, or no enabled window contains the address, all selects are low.
- R3: A window matches when base ≤ address ≤ limit, both bounds inclusive. A window whose base is greater than its limit never matches.
- R4: The SRAM / I/O window has priority over secondary flash, and secondary flash has priority over primary flash. Take primary 0 at 8000h–BFFFh, secondary 0 at 8000h–9FFFh and SRAM at 8000h–87FFh. Then 8000h–87FFh selects SRAM, 8800h–9FFFh selects secondary 0, and A000h–BFFFh selects primary 0.
- R5: A program access is any cycle with `fetch_i` high. A data access has `fetch_i` low and `rd_i` or `wr_i` high, so writes to flash are data accesses. The mapping bits enable each memory in a space:
  - bit0: SRAM in program space
  - bit1: secondary flash in program space
  - bit2: primary flash in program space
  - bit3: secondary flash in data space
  - bit4: primary flash in data space

  SRAM / I/O always answers data accesses. The value 0Ch gives separate spaces. Setting bits 2 and 4 puts primary flash in both spaces.
- R6: At most one select output is high in any cycle. If several windows of one tier match, the lowest-numbered one is selected.
- R7: `cfg_err_o` is high while two or more primary windows, or two or more secondary windows, contain the current address.
- R8: `cfg_err_o` is high while any enabled primary window spans more than 2^`PRI_SZ_LOG2` bytes (16 KiB by default), or any enabled secondary window spans more than 2^`SEC_SZ_LOG2` bytes (8 KiB by default).
- R9: A write with `cfg_we_i` high takes effect on the following cycle.
  - Window w has four registers at address 4w+k: k=0 is the base low byte, k=1 the base high byte, k=2 the limit low byte and k=3 the limit high byte.
  - Window 0 is SRAM. Windows 1..NPRI are primary sectors 0..NPRI-1, and the windows after them are the secondary sectors.
  - The mapping register sits at address 4·(1+NPRI+NSEC), which is 24h by default.
- R10: A memory that is not enabled for the current space takes no part in priority. An address inside its window falls through to a lower tier that is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register file |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Bus address |
| fetch_i | input | 1 | Program-fetch strobe, active high |
| rd_i | input | 1 | Data read strobe, active high |
| wr_i | input | 1 | Data write strobe, active high |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 6 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| sram_sel_o | output | 1 | SRAM / I/O select |
| sec_sel_o | output | NSEC | Secondary flash sector selects |
| pri_sel_o | output | NPRI | Primary flash sector selects |
| cfg_err_o | output | 1 | Configuration error flag |

## Verification
Some properties are checked by assertions on every cycle:
- At most one select is high (one-hot-or-none).
- No strobe means no select.
- Secondary flash is never selected on a fetch when its program bit is clear.
- Primary flash is never selected on a data access when its data bit is clear.
- A mapping-register write lands in the next cycle.

Other behaviour can only be shown by the bench's scenarios, which compare every output against a model:
- the address-dependent priority outcome, including the overlapping-window example;
- fall-through to a lower tier;
- lowest-index choice within a tier;
- the exact sector-size limit behind the error flag.

// File: rtl/memsel_decode.sv
module memsel_decode #(
  parameter int NPRI = 4,
  parameter int NSEC = 4,
  parameter int PRI_SZ_LOG2 = 14,
  parameter int SEC_SZ_LOG2 = 13,
  parameter logic [7:0] MAP_BOOT = 8'h0C,
  localparam int NWIN = 1 + NPRI + NSEC,
  localparam int RAW = $clog2(NWIN*4 + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     addr_i,
  input  logic            fetch_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic            cfg_we_i,
  input  logic [RAW-1:0]  cfg_addr_i,
  input  logic [7:0]      cfg_wdata_i,
  output logic            sram_sel_o,
  output logic [NSEC-1:0] sec_sel_o,
  output logic [NPRI-1:0] pri_sel_o,
  output logic            cfg_err_o
);
  localparam logic [RAW-1:0] MAP_ADDR = RAW'(NWIN*4);
  localparam logic [16:0] PRI_CAP = 17'(1) << PRI_SZ_LOG2;
  localparam logic [16:0] SEC_CAP = 17'(1) << SEC_SZ_LOG2;

  logic [15:0] base_q  [NWIN];
  logic [15:0] limit_q [NWIN];
  logic [7:0]  map_q;
  logic [NWIN-1:0] hit, big;
  logic [RAW-3:0] widx;

  assign widx = cfg_addr_i[RAW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NWIN; w++) begin
        base_q[w]  <= 16'hFFFF;
        limit_q[w] <= 16'h0000;
      end
      map_q <= MAP_BOOT;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == MAP_ADDR) map_q <= cfg_wdata_i;
      else if (cfg_addr_i < MAP_ADDR) begin
        case (cfg_addr_i[1:0])
          2'd0: base_q[widx][7:0]   <= cfg_wdata_i;
          2'd1: base_q[widx][15:8]  <= cfg_wdata_i;
          2'd2: limit_q[widx][7:0]  <= cfg_wdata_i;
          default: limit_q[widx][15:8] <= cfg_wdata_i;
        endcase
      end
    end
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [16:0] span;
    logic        valid;
    assign valid  = limit_q[w] >= base_q[w];
    assign span   = {1'b0, limit_q[w] - base_q[w]};
    assign hit[w] = (addr_i >= base_q[w]) && (addr_i <= limit_q[w]);
    if (w == 0) begin : g_sram
      assign big[w] = 1'b0;
    end else if (w <= NPRI) begin : g_pri
      assign big[w] = valid && (span >= PRI_CAP);
    end else begin : g_sec
      assign big[w] = valid && (span >= SEC_CAP);
    end
  end

  logic [NPRI-1:0] pri_hit;
  logic [NSEC-1:0] sec_hit;
  logic prog, data, sram_en, sec_en, pri_en, sram_win, sec_win, pri_win;

  assign pri_hit = hit[NPRI:1];
  assign sec_hit = hit[NWIN-1:NPRI+1];

  assign prog    = fetch_i;
  assign data    = !fetch_i && (rd_i || wr_i);
  assign sram_en = data || (prog && map_q[0]);
  assign sec_en  = (prog && map_q[1]) || (data && map_q[3]);
  assign pri_en  = (prog && map_q[2]) || (data && map_q[4]);

  assign sram_win = hit[0] && sram_en;
  assign sec_win  = (|sec_hit) && sec_en && !sram_win;
  assign pri_win  = (|pri_hit) && pri_en && !sram_win && !sec_win;

  assign sram_sel_o = sram_win;
  assign sec_sel_o  = sec_win ? (sec_hit & (~sec_hit + 1'b1)) : '0;
  assign pri_sel_o  = pri_win ? (pri_hit & (~pri_hit + 1'b1)) : '0;

  assign cfg_err_o = (|(pri_hit & (pri_hit - 1'b1)))
                   | (|(sec_hit & (sec_hit - 1'b1)))
                   | (|big);
endmodule

module memsel_decode_chk #(
  parameter int NPRI = 4,
  parameter int NSEC = 4,
  parameter int RAW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_i,
  input logic            rd_i,
  input logic            wr_i,
  input logic            cfg_we_i,
  input logic [RAW-1:0]  cfg_addr_i,
  input logic [7:0]      cfg_wdata_i,
  input logic            sram_sel_o,
  input logic [NSEC-1:0] sec_sel_o,
  input logic [NPRI-1:0] pri_sel_o,
  input logic [7:0]      map_q
);
  localparam logic [RAW-1:0] MAP_ADDR = RAW'((1 + NPRI + NSEC) * 4);

  a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sram_sel_o, sec_sel_o, pri_sel_o}));

  a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_i || rd_i || wr_i) |-> (!sram_sel_o && sec_sel_o == '0 && pri_sel_o == '0));

  a_r5_fetch_secondary_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && !map_q[1]) |-> sec_sel_o == '0);

  a_r5_data_primary_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_i && !map_q[4]) |-> pri_sel_o == '0);

  a_r9_map_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_addr_i == MAP_ADDR) |=> map_q == $past(cfg_wdata_i));
endmodule

bind memsel_decode memsel_decode_chk #(.NPRI(NPRI), .NSEC(NSEC), .RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .rd_i(rd_i), .wr_i(wr_i),
  .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
  .sram_sel_o(sram_sel_o), .sec_sel_o(sec_sel_o), .pri_sel_o(pri_sel_o),
  .map_q(map_q)
);

// File: tb/memsel_decode_bench.sv
`timescale 1ns/1ps
module memsel_decode_bench;
  localparam int NPRI = 4, NSEC = 4, NWIN = 9;
  localparam logic [5:0] MAPA = 6'h24;

  logic clk = 0, rst_n = 0;
  logic [15:0] addr = 0;
  logic fetch = 0, rd = 0, wr = 0, we = 0;
  logic [5:0] caddr = 0;
  logic [7:0] cdata = 0;
  logic sram_sel, cfg_err;
  logic [NSEC-1:0] sec_sel;
  logic [NPRI-1:0] pri_sel;

  int nvec = 0, nbad = 0;
  logic [15:0] sb [NWIN];
  logic [15:0] sl [NWIN];
  logic [7:0]  smap;

  always #2 clk = ~clk;

  memsel_decode u_memsel_decode (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .fetch_i(fetch), .rd_i(rd), .wr_i(wr),
    .cfg_we_i(we), .cfg_addr_i(caddr), .cfg_wdata_i(cdata),
    .sram_sel_o(sram_sel), .sec_sel_o(sec_sel), .pri_sel_o(pri_sel), .cfg_err_o(cfg_err));

  function automatic logic [9:0] model(input logic [15:0] a, input logic f, r, w);
    logic pg, dt, s_en, se_en, p_en, s_hit, err;
    logic [3:0] ph, sh, po, so;
    int np, ns;
    pg = f; dt = !f && (r || w);
    s_en  = dt || (pg && smap[0]);
    se_en = (pg && smap[1]) || (dt && smap[3]);
    p_en  = (pg && smap[2]) || (dt && smap[4]);
    s_hit = (a >= sb[0]) && (a <= sl[0]);
    ph = 0; sh = 0; po = 0; so = 0; np = 0; ns = 0; err = 0;
    for (int i = 0; i < 4; i++) begin
      if (a >= sb[1+i] && a <= sl[1+i]) begin ph[i] = 1; np++; end
      if (a >= sb[5+i] && a <= sl[5+i]) begin sh[i] = 1; ns++; end
      if (sl[1+i] >= sb[1+i] && int'(sl[1+i]) - int'(sb[1+i]) + 1 > 16384) err = 1;
      if (sl[5+i] >= sb[5+i] && int'(sl[5+i]) - int'(sb[5+i]) + 1 > 8192) err = 1;
    end
    if (np > 1 || ns > 1) err = 1;
    s_hit = s_hit && s_en;
    if (!s_hit && se_en && sh != 0) begin
      for (int i = 3; i >= 0; i--) if (sh[i]) so = 4'(1 << i);
    end else if (!s_hit && p_en && ph != 0) begin
      for (int i = 3; i >= 0; i--) if (ph[i]) po = 4'(1 << i);
    end
    return {err, s_hit, so, po};
  endfunction

  task automatic wreg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; caddr = a; cdata = d;
    @(negedge clk); we = 0;
    if (a == MAPA) smap = d;
    else case (a[1:0])
      2'd0: sb[a[5:2]][7:0] = d;
      2'd1: sb[a[5:2]][15:8] = d;
      2'd2: sl[a[5:2]][7:0] = d;
      default: sl[a[5:2]][15:8] = d;
    endcase
  endtask

  task automatic setwin(input int w, input logic [15:0] b, input logic [15:0] l);
    wreg(6'(4*w), b[7:0]);   wreg(6'(4*w+1), b[15:8]);
    wreg(6'(4*w+2), l[7:0]); wreg(6'(4*w+3), l[15:8]);
  endtask

  task automatic apply(input logic [15:0] a, input logic f, r, w, input string tag);
    logic [9:0] exp, act;
    @(negedge clk); addr = a; fetch = f; rd = r; wr = w;
    #1;
    exp = model(a, f, r, w);
    act = {cfg_err, sram_sel, sec_sel, pri_sel};
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s addr=%h f%0d r%0d w%0d actual=%b expected=%b", tag, a, f, r, w, act, exp);
    end
  endtask

  task automatic clearall();
    for (int w = 0; w < NWIN; w++) setwin(w, 16'hFFFF, 16'h0000);
  endtask

  initial begin
    #(4*200000);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [15:0] b, l;
    void'($urandom(32'h5EED_0C1E));
    for (int w = 0; w < NWIN; w++) begin sb[w] = 16'hFFFF; sl[w] = 16'h0000; end
    smap = 8'h0C;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: boot state, no window enabled
    apply(16'h8000, 0, 1, 0, "R1");
    apply(16'h0000, 1, 0, 0, "R1");
    // R1/R5: boot map 0Ch -> primary on fetch only, secondary on data only
    setwin(1, 16'h0000, 16'h3FFF);
    setwin(5, 16'h4000, 16'h5FFF);
    apply(16'h1234, 1, 0, 0, "R1");
    apply(16'h1234, 0, 1, 0, "R5");
    apply(16'h4100, 0, 1, 0, "R5");
    apply(16'h4100, 1, 0, 0, "R5");
    // R2: no strobe, outside window
    apply(16'h1234, 0, 0, 0, "R2");
    apply(16'hE000, 1, 0, 0, "R2");
    // R3: inclusive bounds, reversed window disabled
    apply(16'h3FFF, 1, 0, 0, "R3");
    apply(16'h4000, 1, 0, 0, "R3");
    setwin(2, 16'h7000, 16'h6000);
    apply(16'h6800, 1, 0, 0, "R3");
    clearall();
    // R4: overlap example, R9 map write takes effect next cycle
    wreg(MAPA, 8'h1F);
    setwin(1, 16'h8000, 16'hBFFF);
    setwin(5, 16'h8000, 16'h9FFF);
    setwin(0, 16'h8000, 16'h87FF);
    apply(16'h8000, 0, 1, 0, "R4");
    apply(16'h87FF, 0, 1, 0, "R4");
    apply(16'h8800, 0, 1, 0, "R4");
    apply(16'h9FFF, 0, 0, 1, "R4");
    apply(16'hA000, 0, 1, 0, "R4");
    apply(16'hBFFF, 1, 0, 0, "R4");
    // R10: SRAM not in program space, falls to secondary
    wreg(MAPA, 8'h1E);
    apply(16'h8100, 1, 0, 0, "R10");
    wreg(MAPA, 8'h14);
    apply(16'h8100, 1, 0, 0, "R10");
    apply(16'h8900, 0, 1, 0, "R10");
    // R5: fetch has precedence over rd/wr
    apply(16'h8100, 1, 1, 1, "R5");
    // R6/R7: same-tier overlap
    setwin(3, 16'hA000, 16'hAFFF);
    apply(16'hA800, 1, 0, 0, "R6");
    apply(16'hB800, 1, 0, 0, "R7");
    // R8: sector size limit
    clearall();
    setwin(1, 16'h0000, 16'h3FFF);
    apply(16'hF000, 0, 0, 0, "R8");
    setwin(1, 16'h0000, 16'h4000);
    apply(16'hF000, 0, 0, 0, "R8");
    setwin(1, 16'h0000, 16'h0FFF);
    setwin(6, 16'h2000, 16'h4000);
    apply(16'hF000, 0, 0, 0, "R8");

    // random mix
    for (int k = 0; k < 40; k++) begin
      for (int w = 0; w < NWIN; w++) begin
        b = 16'(($urandom % 16) << 12) + 16'(($urandom % 4) << 10);
        l = b + 16'(($urandom % 12) << 10) + 16'h3FF;
        if ($urandom % 10 == 0) l = b + 16'h4000;
        if ($urandom % 8 == 0) setwin(w, 16'hFFFF, 16'h0000);
        else setwin(w, b, l);
      end
      wreg(MAPA, 8'($urandom));
      for (int j = 0; j < 60; j++)
        apply(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R3 R4 R5 R6 R7 R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule